// File: doc/BRIEF.md
# SDRAM Auto-Refresh Scheduler

This block decides when an SDRAM needs refreshing and drives the command sequence that performs it. A compare-match interval timer counts ticks of a prescaled clock. When its count equals a programmed constant, it posts a refresh request and starts counting again from zero. Requests wait in a small counter until the memory bus reports idle. The scheduler then takes the bus, marks itself busy, and runs a burst of refresh operations.

Each operation in the burst is a precharge-all command, a programmable run of idle cycles, a refresh command, and a programmable lockout that covers the refresh cycle time. The burst repeats a programmed number of times. Only one command leaves the block per cycle.

All settings are loaded while the clock select is zero. Refreshing is then enabled by writing a non-zero clock select.

Top module: `refresh_scheduler`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cmd` is NOP, `busy` is 0 and `rq_count` is 0. Reset taken during a burst abandons the burst.
- R2: With `clk_sel` = 0 the interval counter holds its value and no request is posted, so `rq_count` never rises.
- R3: `clk_sel` = s (s ≥ 1) gives one tick every D = 4^(s-1) clock cycles. With `cmp_val` = C, a match occurs every (C+1)·D cycles. From reset release with the bus idle, the first PALL appears in the cycle after clock edge D·(C+1)+1.
- R4: A posted request starts a burst only when `bus_idle` is 1 while the scheduler is not busy. PALL appears in the cycle after that edge, and no command other than NOP appears while the request waits.
- R5: A burst is N operations, with N = `burst_len`, and 0 means 1. Each operation is one PALL cycle, `pre_wait` NOP cycles, one REF cycle, then `rec_wait` NOP cycles. With `pre_wait` = 0, REF directly follows PALL.
- R6: `busy` is 1 from the first PALL of a burst through its last recovery cycle, and 0 in the cycle after that.
- R7: `rq_count` increments on each match and decrements when a burst starts. A match in the same cycle as a burst start leaves it unchanged. Matches during a burst are kept, and the count saturates at 2^PEND_W−1 (7 by default).
- R8: `cmd` carries exactly one command per cycle, encoded NOP = 0, PALL = 1, REF = 2. The value 3 never occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_sel | input | 3 | Tick prescale select; 0 stops the timer |
| cmp_val | input | 8 | Interval compare constant |
| burst_len | input | 3 | Refreshes per request (0 means 1) |
| pre_wait | input | 2 | Idle cycles between PALL and REF |
| rec_wait | input | 2 | Lockout cycles after REF |
| bus_idle | input | 1 | Bus is free to be taken for refresh |
| cmd | output | 2 | Command: 0 NOP, 1 PALL, 2 REF |
| busy | output | 1 | Refresh burst owns the bus |
| rq_count | output | 3 | Refresh requests waiting |

## Verification
Two functions can fall in the same cycle: a fresh compare match, and a burst start that consumes a waiting request. The bench holds the bus busy until one request is waiting. It then raises `bus_idle` exactly one cycle before the second match, so that the start and the match share the same edge. The test passes only if `rq_count` stays at 1 and PALL appears. Separate tests cover matches that pile up under a long burst and saturation of the request count.

// File: rtl/refresh_pkg.sv
// Shared types for the refresh scheduler: command codes and sequencer states.
// Assumes a 2-bit command bus decoded by the SDRAM pin driver downstream.
package refresh_pkg;

    typedef enum logic [1:0] {
        CMD_NOP  = 2'd0,
        CMD_PALL = 2'd1,
        CMD_REF  = 2'd2
    } rcmd_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PALL  = 3'd1,
        ST_PWAIT = 3'd2,
        ST_REF   = 3'd3,
        ST_RWAIT = 3'd4
    } rseq_e;

endpackage

// File: rtl/refresh_timer.sv
// Interval timer: a free-running prescaler gives a tick every 4^(sel-1)
// cycles. On each tick the interval counter is compared with the constant:
// on equality a one-cycle match pulse is raised and the count clears,
// otherwise it increments. Select 0 freezes the counter.
// Assumes settings are stable while the select is non-zero.
module refresh_timer #(
    parameter int SEL_W = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic [CNT_W-1:0] cmp_val,
    output logic             match
);
    localparam int PRE_W = 2 * ((1 << SEL_W) - 2);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   pow_w;
    logic [PRE_W-1:0] low_mask;
    logic [SEL_W:0]   shamt;
    logic [CNT_W-1:0] cnt_q;
    logic             run;
    logic             tick;

    assign run = (clk_sel != '0);

    // Prescaler: free-running cycle counter shared by all selects.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // Tick decode: low 2*(sel-1) prescaler bits all ones.
    always_comb begin
        shamt    = {clk_sel - SEL_W'(1), 1'b0};
        pow_w    = (PRE_W+1)'(1) << shamt;
        low_mask = run ? PRE_W'(pow_w - 1'b1) : '0;
        tick     = run & (&(pre_q | ~low_mask));
    end

    assign match = tick && (cnt_q == cmp_val);

    // Interval counter: clear on match, count on tick, hold when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (match) cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/refresh_request_counter.sv
// Pending-request counter: adds timer matches, removes requests taken by
// the sequencer, saturates at its maximum so no overflow wraps to zero.
// Assumes take is only asserted while the count is non-zero.
module refresh_request_counter #(
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add,
    input  logic              take,
    output logic [PEND_W-1:0] count
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    // Count update: add and take in one cycle cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (add && !take && count != PEND_MAX)
            count <= count + 1'b1;
        else if (take && !add)
            count <= count - 1'b1;
    end

endmodule

// File: rtl/refresh_sequencer.sv
// Command sequencer: on a granted request issues PALL, pre_wait idle
// cycles, REF, rec_wait lockout cycles, repeated burst_len times (0 = 1).
// The command is decoded from the state register, one per cycle.
// Assumes wait and length settings stay fixed during a burst.
module refresh_sequencer
    import refresh_pkg::*;
#(
    parameter int LEN_W  = 3,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pending,
    input  logic              bus_idle,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [WAIT_W-1:0] pre_wait,
    input  logic [WAIT_W-1:0] rec_wait,
    output logic              take,
    output logic              busy,
    output rcmd_e             cmd
);
    rseq_e             st_q;
    logic [LEN_W-1:0]  left_q;
    logic [WAIT_W-1:0] wait_q;

    assign take = (st_q == ST_IDLE) && pending && bus_idle;
    assign busy = (st_q != ST_IDLE);

    // Command decode: only the PALL and REF states drive a command.
    always_comb begin
        case (st_q)
            ST_PALL: cmd = CMD_PALL;
            ST_REF:  cmd = CMD_REF;
            default: cmd = CMD_NOP;
        endcase
    end

    // State walk through one burst of precharge/refresh operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            left_q <= '0;
            wait_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (take) begin
                        st_q   <= ST_PALL;
                        left_q <= (burst_len == '0) ? LEN_W'(1) : burst_len;
                    end
                end
                ST_PALL: begin
                    if (pre_wait == '0) begin
                        st_q <= ST_REF;
                    end else begin
                        st_q   <= ST_PWAIT;
                        wait_q <= pre_wait;
                    end
                end
                ST_PWAIT: begin
                    if (wait_q == WAIT_W'(1)) st_q <= ST_REF;
                    else                      wait_q <= wait_q - 1'b1;
                end
                ST_REF: begin
                    left_q <= left_q - 1'b1;
                    if (rec_wait != '0) begin
                        st_q   <= ST_RWAIT;
                        wait_q <= rec_wait;
                    end else if (left_q == LEN_W'(1)) begin
                        st_q <= ST_IDLE;
                    end else begin
                        st_q <= ST_PALL;
                    end
                end
                ST_RWAIT: begin
                    if (wait_q == WAIT_W'(1))
                        st_q <= (left_q == '0) ? ST_IDLE : ST_PALL;
                    else
                        wait_q <= wait_q - 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/refresh_scheduler.sv
// Top of the SDRAM auto-refresh scheduler: interval timer, pending-request
// counter and command sequencer. Assumes settings are written while
// clk_sel is 0 and that bus_idle is only asserted when the bus may be taken.
module refresh_scheduler
    import refresh_pkg::*;
#(
    parameter int SEL_W  = 3,
    parameter int CNT_W  = 8,
    parameter int LEN_W  = 3,
    parameter int WAIT_W = 2,
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  clk_sel,
    input  logic [CNT_W-1:0]  cmp_val,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic [WAIT_W-1:0] pre_wait,
    input  logic [WAIT_W-1:0] rec_wait,
    input  logic              bus_idle,
    output logic [1:0]        cmd,
    output logic              busy,
    output logic [PEND_W-1:0] rq_count
);
    logic  match;
    logic  take;
    rcmd_e cmd_e;

    refresh_timer #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_sel (clk_sel),
        .cmp_val (cmp_val),
        .match   (match)
    );

    refresh_request_counter #(.PEND_W(PEND_W)) u_rq (
        .clk   (clk),
        .rst_n (rst_n),
        .add   (match),
        .take  (take),
        .count (rq_count)
    );

    refresh_sequencer #(.LEN_W(LEN_W), .WAIT_W(WAIT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (rq_count != '0),
        .bus_idle  (bus_idle),
        .burst_len (burst_len),
        .pre_wait  (pre_wait),
        .rec_wait  (rec_wait),
        .take      (take),
        .busy      (busy),
        .cmd       (cmd_e)
    );

    assign cmd = cmd_e;

endmodule

// File: rtl/refresh_scheduler_chk.sv
// Property checker for refresh_scheduler, attached by bind below.
// Observes ports only; assumes settings are held still during a burst.
module refresh_scheduler_chk #(
    parameter int SEL_W  = 3,
    parameter int WAIT_W = 2,
    parameter int PEND_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  clk_sel,
    input logic [WAIT_W-1:0] pre_wait,
    input logic              bus_idle,
    input logic [1:0]        cmd,
    input logic              busy,
    input logic [PEND_W-1:0] rq_count
);
    localparam logic [PEND_W-1:0] PMAX = '1;

    // R1: first cycle out of reset is quiet.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (cmd == 2'd0 && !busy && rq_count == '0));

    // R2: a stopped timer never adds a request.
    a_r2_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == '0) |=> (rq_count <= $past(rq_count)));

    // R4: a burst starts only from a waiting request on an idle bus.
    a_r4_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(bus_idle) && $past(rq_count) != '0 && cmd == 2'd1));

    // R5: zero precharge wait puts REF right after PALL.
    a_r5_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 2'd1 && pre_wait == '0) |=> (cmd == 2'd2));

    // R6: any command implies the bus is held.
    a_r6_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != 2'd0) |-> busy);

    // R7: the saturated count never wraps to a small value.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_count == PMAX) |=> (rq_count >= PMAX - 1'b1));

    // R8: only legal command codes.
    a_r8_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        cmd != 2'd3);

endmodule

bind refresh_scheduler refresh_scheduler_chk #(
    .SEL_W(SEL_W), .WAIT_W(WAIT_W), .PEND_W(PEND_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_sel  (clk_sel),
    .pre_wait (pre_wait),
    .bus_idle (bus_idle),
    .cmd      (cmd),
    .busy     (busy),
    .rq_count (rq_count)
);

// File: tb/sim_refresh_scheduler.sv
`timescale 1ns/1ps
module sim_refresh_scheduler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_sel = '0;
    logic [7:0] cmp_val = '0;
    logic [2:0] burst_len = '0;
    logic [1:0] pre_wait = '0;
    logic [1:0] rec_wait = '0;
    logic       bus_idle = 1'b0;
    logic [1:0] cmd;
    logic       busy;
    logic [2:0] rq_count;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    refresh_scheduler u0 (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .cmp_val(cmp_val),
        .burst_len(burst_len), .pre_wait(pre_wait), .rec_wait(rec_wait),
        .bus_idle(bus_idle), .cmd(cmd), .busy(busy), .rq_count(rq_count)
    );

    // Vector fields: sel[17:15] cmp[14:7] len[6:4] pre[3:2] rec[1:0]
    localparam logic [17:0] VEC [5] = '{
        {3'd1, 8'd20,  3'd2, 2'd1, 2'd1},
        {3'd1, 8'd7,   3'd0, 2'd0, 2'd0},
        {3'd1, 8'd100, 3'd7, 2'd3, 2'd3},
        {3'd2, 8'd10,  3'd1, 2'd2, 2'd0},
        {3'd3, 8'd3,   3'd3, 2'd0, 2'd2}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock edge; returns at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        @(negedge clk);

        // R1: reset state
        do_reset();
        check(cmd == 2'd0 && !busy && rq_count == 0, "R1 reset outputs", {cmd, busy, rq_count}, 0);

        // Vector walk: R3 start time, R5 sequence, R6 busy window
        foreach (VEC[i]) begin
            int d, first, n, errs, berr, mism;
            bit quiet;
            clk_sel   = VEC[i][17:15];
            cmp_val   = VEC[i][14:7];
            burst_len = VEC[i][6:4];
            pre_wait  = VEC[i][3:2];
            rec_wait  = VEC[i][1:0];
            bus_idle  = 1'b1;
            do_reset();
            d     = 1 << (2 * (int'(clk_sel) - 1));
            first = d * (int'(cmp_val) + 1) + 1;
            n     = (burst_len == 0) ? 1 : int'(burst_len);
            quiet = 1;
            for (int k = 1; k < first; k++) begin
                step();
                if (cmd != 2'd0) quiet = 0;
            end
            check(quiet, "R3 no command before match", int'(quiet), 1);
            step();
            check(cmd == 2'd1, "R3 first PALL time", cmd, 1);
            errs = 0;
            berr = 0;
            mism = -1;
            for (int b = 0; b < n; b++) begin
                if (b > 0) begin
                    step();
                    if (cmd != 2'd1) begin errs++; if (mism < 0) mism = cmd; end
                    if (!busy) berr++;
                end
                for (int w = 0; w < int'(pre_wait); w++) begin
                    step();
                    if (cmd != 2'd0) begin errs++; if (mism < 0) mism = cmd; end
                    if (!busy) berr++;
                end
                step();
                if (cmd != 2'd2) begin errs++; if (mism < 0) mism = cmd; end
                if (!busy) berr++;
                for (int w = 0; w < int'(rec_wait); w++) begin
                    step();
                    if (cmd != 2'd0) begin errs++; if (mism < 0) mism = cmd; end
                    if (!busy) berr++;
                end
            end
            check(errs == 0, "R5 burst command sequence", errs, 0);
            check(berr == 0, "R6 busy through burst", berr, 0);
            step();
            check(!busy && cmd == 2'd0, "R6 busy drops after last recovery", {busy, cmd}, 0);
        end

        // R2: stopped timer posts nothing
        clk_sel = 3'd0; cmp_val = 8'd2; burst_len = 3'd1; pre_wait = 2'd0; rec_wait = 2'd0;
        bus_idle = 1'b1;
        do_reset();
        begin
            bit seen = 0;
            for (int k = 0; k < 60; k++) begin
                step();
                if (rq_count != 0 || cmd != 2'd0) seen = 1;
            end
            check(!seen, "R2 stopped timer quiet", int'(seen), 0);
        end

        // R4: request waits for bus idle
        clk_sel = 3'd1; cmp_val = 8'd5; bus_idle = 1'b0;
        do_reset();
        repeat (6) step();
        check(rq_count == 1 && cmd == 2'd0, "R4 request held while bus busy", rq_count, 1);
        repeat (4) step();
        check(!busy && cmd == 2'd0, "R4 no command before idle", {busy, cmd}, 0);
        bus_idle = 1'b1;
        step();
        check(cmd == 2'd1 && busy, "R4 PALL after bus idle", cmd, 1);
        check(rq_count == 0, "R7 start consumes request", rq_count, 0);

        // R7: match and burst start on the same edge
        bus_idle = 1'b0;
        do_reset();
        repeat (11) step();
        check(rq_count == 1, "R7 one waiting before coincidence", rq_count, 1);
        bus_idle = 1'b1;
        step();
        check(rq_count == 1, "R7 match and start same cycle", rq_count, 1);
        check(cmd == 2'd1, "R7 burst started on coincidence", cmd, 1);

        // R7: saturation at 7
        bus_idle = 1'b0; cmp_val = 8'd1;
        do_reset();
        repeat (30) step();
        check(rq_count == 3'd7, "R7 saturates", rq_count, 7);

        // R7: matches during a long burst are kept
        bus_idle = 1'b1; cmp_val = 8'd9; burst_len = 3'd7; pre_wait = 2'd3; rec_wait = 2'd3;
        do_reset();
        repeat (60) step();
        check(rq_count == 3'd5 && busy, "R7 requests kept during burst", rq_count, 5);

        // R1: reset during a burst abandons it
        rst_n = 1'b0;
        step();
        check(!busy && cmd == 2'd0 && rq_count == 0, "R1 reset mid burst", {busy, cmd, rq_count}, 0);
        rst_n = 1'b1;
        step();

        finish_run();
    end
endmodule